// File: doc/BRIEF.md
# Edge-Triggered Input Capture Timer

This block is a 16-bit up-counter paired with a capture register that is loaded from an external pin. The counter advances by one on every cycle in which the count-enable strobe is high and the run bit is set. It either wraps over its full range or returns to zero after it matches a programmable compare value. The pin passes through a two-flop synchronizer. Its rising edge, its falling edge, or both edges produce a capture trigger. Each trigger copies the counter into the capture register and raises a sticky interrupt flag.

Two uses follow from this. In both-edge mode, the difference between successive captures gives the high and low periods of the pin. When software changes the edge selection, that change can itself fire a trigger, depending on the present synchronized pin level, in the same way a real edge would. Software reaches the controls, the compare value, the capture value and the live count through a small byte-wide register port.

Top module: `cap_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, the capture register, the control byte and the interrupt flag read 0, the compare register reads 0xFFFF, and `irq` is low.
- R2: With the run bit set, the counter rises by exactly one on each clock cycle in which `cnt_tick` is high. With the run bit clear, or with `cnt_tick` low, it holds its value.
- R3: With clear-on-match set and the counter equal to the compare value, the next counted cycle loads 0x0000 instead of incrementing.
- R4: With clear-on-match clear, the counter passes the compare value and wraps from 0xFFFF to 0x0000.
- R5: In single-edge mode, a trigger fires only on the edge that the edge-select bit names (1 = rising, 0 = falling). The opposite edge has no effect on `irq`. A pin change triggers on the third rising clock edge after the pin changes.
- R6: In both-edge mode, every rising and every falling pin edge fires a trigger, whatever the edge-select bit holds.
- R7: A trigger stores the counter value of that cycle in the capture register. A later trigger overwrites it even if it has not been read.
- R8: Writing the edge-select bit from 0 to 1 while the synchronized pin is high, or from 1 to 0 while it is low, fires a trigger (capture and flag). The other two combinations do not.
- R9: The interrupt flag, driven on `irq`, stays set until a write of 1 to status bit 0. A write of 0 has no effect. A trigger in the same cycle as a clearing write leaves the flag set.
- R10: The register map is as follows. Address 0 is control: bit0 run, bit1 clear-on-match, bit2 edge-select, bit3 both-edge. Address 1 is status: bit0 flag. Addresses 2/3 are compare low/high. Addresses 4/5 are capture low/high. Addresses 6/7 are counter low/high. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable, one count per high cycle |
| ext_in | input | 1 | Asynchronous external pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A capture trigger and a software write that clears the flag can land on the same clock edge. The bench sets up this collision on purpose. It changes the pin exactly two clock cycles before it issues the status write, so that the synchronized edge and the write fall on the same edge. The flag must then read set. A plain clearing write with no edge pending must still drop the flag.

// File: rtl/cap_timer_pkg.sv
`timescale 1ns/1ps
// Package: register addresses and control-byte layout shared by the
// capture timer modules. Assumes a byte-wide register port.
package cap_timer_pkg;
    localparam int ADR_CTRL = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_CMP  = 2;   // first compare byte; capture and count follow

    typedef struct packed {
        logic both;   // bit3: trigger on either edge
        logic rise;   // bit2: edge select, 1 = rising
        logic clr;    // bit1: clear on compare match
        logic run;    // bit0: counter enable
    } ctl_t;
endpackage

// File: rtl/ct_input_stage.sv
`timescale 1ns/1ps
// Synchronizes the external pin and turns its edges, plus software changes of
// the edge select, into a one-cycle capture trigger. Assumes STAGES >= 2.
module ct_input_stage #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sel_rise,
    input  logic both,
    output logic level,
    output logic trig
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              sel_prev_q;
    logic              rise_hit, fall_hit, edge_hit, switch_hit;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end

    assign level = sync_q[STAGES-1];

    // Remember last level and last edge select for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            sel_prev_q <= 1'b0;
        end else begin
            prev_q     <= level;
            sel_prev_q <= sel_rise;
        end
    end

    // Combine pin edges and select changes into a trigger.
    always_comb begin
        rise_hit   = level & ~prev_q;
        fall_hit   = ~level & prev_q;
        edge_hit   = both ? (rise_hit | fall_hit) : (sel_rise ? rise_hit : fall_hit);
        switch_hit = (sel_rise & ~sel_prev_q & level) | (~sel_rise & sel_prev_q & ~level);
        trig       = edge_hit | switch_hit;
    end
endmodule

// File: rtl/ct_counter.sv
`timescale 1ns/1ps
// Up-counter with optional clear on compare match. Counts one per cycle while
// run and tick are both high; assumes tick is already synchronous to clk.
module ct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         clr_en,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt
);
    logic at_match;
    assign at_match = clr_en && (cnt == cmp);

    // Advance, wrap or reload the count.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (run && tick) cnt <= at_match ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/ct_regfile.sv
`timescale 1ns/1ps
// Byte-addressed control, compare, capture and flag registers with a
// combinational read mux. Assumes W is a multiple of 8.
module ct_regfile
    import cap_timer_pkg::*;
#(
    parameter int W      = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [W-1:0]      cnt,
    input  logic              trig,
    output ctl_t              ctl,
    output logic [W-1:0]      cmp,
    output logic [W-1:0]      cap,
    output logic              flag,
    output logic              flag_clr
);
    localparam int BYTES   = W / 8;
    localparam int ADR_CAP = ADR_CMP + BYTES;
    localparam int ADR_CNT = ADR_CAP + BYTES;

    assign flag_clr = we && (int'(addr) == ADR_STAT) && wdata[0];

    // Control byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctl <= '0;
        else if (we && int'(addr) == ADR_CTRL)   ctl <= ctl_t'(wdata[3:0]);
    end

    // Compare register, written one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp <= '1;
        else begin
            for (int b = 0; b < BYTES; b++)
                if (we && int'(addr) == ADR_CMP + b) cmp[8*b +: 8] <= wdata;
        end
    end

    // Capture register loads the counter on every trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap <= '0;
        else if (trig) cap <= cnt;
    end

    // Sticky flag: set by trigger, which wins over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (trig)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        if (int'(addr) == ADR_CTRL) rdata = {4'b0, ctl};
        if (int'(addr) == ADR_STAT) rdata = {7'b0, flag};
        for (int b = 0; b < BYTES; b++) begin
            if (int'(addr) == ADR_CMP + b) rdata = cmp[8*b +: 8];
            if (int'(addr) == ADR_CAP + b) rdata = cap[8*b +: 8];
            if (int'(addr) == ADR_CNT + b) rdata = cnt[8*b +: 8];
        end
    end
endmodule

// File: rtl/cap_timer.sv
`timescale 1ns/1ps
// Top of the input-capture timer: synchronizer/trigger stage, counter and
// register file. Assumes cnt_tick is synchronous and ext_in is asynchronous.
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cnt_tick,
    input  logic                                  ext_in,
    input  logic                                  reg_we,
    input  logic [$clog2(2+3*(CNT_W/8))-1:0]      reg_addr,
    input  logic [7:0]                            reg_wdata,
    output logic [7:0]                            reg_rdata,
    output logic                                  irq
);
    localparam int ADDR_W = $clog2(2 + 3 * (CNT_W / 8));

    ctl_t             ctl;
    logic             run_en, clr_en, sel_rise, both_en;
    logic [CNT_W-1:0] cnt_q, cmp_q, cap_q;
    logic             trig, pin_lvl, flag_q, flag_clr;

    assign run_en   = ctl.run;
    assign clr_en   = ctl.clr;
    assign sel_rise = ctl.rise;
    assign both_en  = ctl.both;
    assign irq      = flag_q;

    ct_input_stage #(.STAGES(SYNC_STAGES)) u_in (
        .clk(clk), .rst_n(rst_n), .pin(ext_in), .sel_rise(sel_rise),
        .both(both_en), .level(pin_lvl), .trig(trig)
    );

    ct_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_en), .tick(cnt_tick),
        .clr_en(clr_en), .cmp(cmp_q), .cnt(cnt_q)
    );

    ct_regfile #(.W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cnt(cnt_q), .trig(trig),
        .ctl(ctl), .cmp(cmp_q), .cap(cap_q), .flag(flag_q), .flag_clr(flag_clr)
    );

    logic unused_lvl;
    assign unused_lvl = pin_lvl;
endmodule

// File: rtl/cap_timer_chk.sv
`timescale 1ns/1ps
// Checker for cap_timer, attached by bind. Relates counter, capture and flag
// state across clock edges.
module cap_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         tick,
    input logic         clr_en,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp,
    input logic [W-1:0] cap,
    input logic         trig,
    input logic         flag,
    input logic         flag_clr
);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) |=> $stable(cnt));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !(clr_en && cnt == cmp)) |=> cnt == ($past(cnt) + {{(W-1){1'b0}}, 1'b1}));

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && clr_en && cnt == cmp) |=> cnt == '0);

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> cap == $past(cnt));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> flag);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !trig) |=> !flag);
endmodule

bind cap_timer cap_timer_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(cnt_tick), .clr_en(clr_en),
    .cnt(cnt_q), .cmp(cmp_q), .cap(cap_q), .trig(trig), .flag(flag_q),
    .flag_clr(flag_clr)
);

// File: tb/cap_timer_test.sv
`timescale 1ns/1ps
module cap_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       ext_in = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    cap_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ext_in(ext_in),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
    );

    // Vector: {both, rise, pin_start, pin_end, expect_trigger}
    localparam logic [4:0] VEC [7] = '{
        5'b01011, 5'b01100, 5'b00101, 5'b00010,
        5'b10011, 5'b10101, 5'b11011
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] base, output logic [15:0] v);
        @(negedge clk); addr = base; #0.5 v[7:0] = rdata;
        addr = base + 3'd1; #0.5 v[15:8] = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic pin(input logic v);
        @(negedge clk); ext_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd16(3'd6, v); chk("R1 count", v, 16'h0000);
        rd16(3'd4, v); chk("R1 capture", v, 16'h0000);
        rd16(3'd2, v); chk("R1 compare", v, 16'hFFFF);
        rd16(3'd0, v); chk("R1 ctrl/status", v, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0);

        // R2 counting and holding
        wr(3'd0, 8'h01); ticks(5);
        rd16(3'd6, v); chk("R2 count", v, 16'd5);
        wr(3'd0, 8'h00); ticks(3);
        rd16(3'd6, v); chk("R2 hold", v, 16'd5);

        // R3 clear on match with compare 7
        wr(3'd2, 8'h07); wr(3'd3, 8'h00);
        wr(3'd0, 8'h03); ticks(3);
        rd16(3'd6, v); chk("R3 reload", v, 16'd0);
        ticks(2);
        rd16(3'd6, v); chk("R3 after reload", v, 16'd2);

        // R4 free run past compare and full wrap
        wr(3'd2, 8'h02); wr(3'd0, 8'h01); ticks(1);
        rd16(3'd6, v); chk("R4 pass compare", v, 16'd3);
        ticks(65533);
        rd16(3'd6, v); chk("R4 wrap", v, 16'd0);

        // Freeze the counter at 0x0123 for capture checks
        ticks(16'h0123); wr(3'd0, 8'h00);
        rd16(3'd6, v); chk("R2 freeze", v, 16'h0123);

        // R5/R6 edge table
        for (int i = 0; i < 7; i++) begin
            pin(VEC[i][2]);
            wr(3'd0, {4'b0, VEC[i][4], VEC[i][3], 2'b00});
            idle(3);
            wr(3'd1, 8'h01); idle(1);
            chk("R9 cleared before edge", {15'b0, irq}, 16'h0);
            pin(VEC[i][1]);
            chk(VEC[i][4] ? "R6 both-edge trigger" : "R5 single-edge trigger",
                {15'b0, irq}, {15'b0, VEC[i][0]});
            if (VEC[i][0]) begin
                rd16(3'd4, v); chk("R7 capture value", v, 16'h0123);
            end
        end

        // R8 edge-select switching
        wr(3'd0, 8'h01); ticks(16); wr(3'd0, 8'h00);
        pin(1'b1); wr(3'd1, 8'h01); idle(2);
        wr(3'd0, 8'h04); idle(2);
        chk("R8 fall->rise pin high", {15'b0, irq}, 16'h1);
        rd16(3'd4, v); chk("R8 capture on switch", v, 16'h0133);
        wr(3'd1, 8'h01); wr(3'd0, 8'h00); idle(2);
        chk("R8 rise->fall pin high", {15'b0, irq}, 16'h0);
        pin(1'b0); wr(3'd1, 8'h01); wr(3'd0, 8'h04); idle(2);
        chk("R8 fall->rise pin low", {15'b0, irq}, 16'h0);
        wr(3'd0, 8'h00); idle(2);
        chk("R8 rise->fall pin low", {15'b0, irq}, 16'h1);

        // R7 overwrite without read
        wr(3'd0, 8'h05); ticks(16'h20); wr(3'd0, 8'h04);
        pin(1'b1);
        rd16(3'd4, v); chk("R7 overwrite", v, 16'h0153);

        // R9 trigger and clear on the same edge
        pin(1'b0); wr(3'd1, 8'h01); idle(1);
        chk("R9 plain clear", {15'b0, irq}, 16'h0);
        @(negedge clk); ext_in = 1'b1;
        @(negedge clk);
        wr(3'd1, 8'h01); idle(1);
        chk("R9 set wins over clear", {15'b0, irq}, 16'h1);
        wr(3'd1, 8'h00); idle(1);
        chk("R9 write 0 ignored", {15'b0, irq}, 16'h1);
        wr(3'd1, 8'h01); idle(1);
        chk("R9 write 1 clears", {15'b0, irq}, 16'h0);

        // R10 control readback
        wr(3'd0, 8'h0B);
        rd16(3'd0, v); chk("R10 ctrl byte", {8'h00, v[7:0]}, 16'h000B);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule